// File: doc/BRIEF.md
# PLL Feedback Multiplier Configuration Register

This block keeps the feedback multiplication setting of a PLL's VCO in a 9-bit register that is loaded through a single-cycle synchronous write port. Software may change the setting only while the PLL is stopped. A write is accepted only when the enable input and the lock-ready input are both low. In any other case the write is dropped, the stored value stays as it was, and a one-cycle rejection pulse is given instead.

The stored code is decoded into the real multiplier, which is the code plus one. From that multiplier, an integer reference frequency in MHz and a VCO range select, the block checks its own configuration all the time. It raises separate registered flags for an illegal code, a reference frequency outside its legal band, and a VCO frequency outside the selected window. The VCO frequency is the reference frequency times the multiplier, with no fractional part. The analog loop and the clock dividers sit outside this block.

Top module: `pll_mult_cfg`

## Requirements
- R1: While reset is held, and at the first cycle after it, the stored code reads 128, the multiplier reads 129, and all three error flags and the rejection output are 0.
- R2: A write with `pll_on`=0 and `pll_rdy`=0 at a rising edge stores `wr_code`, and `rd_code` shows the new value from that edge on.
- R3: A write while `pll_on`=1 or `pll_rdy`=1 leaves the stored code unchanged. `wr_reject` is 1 for exactly the cycle after each such edge and is 0 otherwise.
- R4: `mult` always equals the stored code plus one, as a 10-bit value.
- R5: `code_err` is 1 for stored codes 0 to 6 and 420 to 511, and 0 for codes 7 to 419.
- R6: `ref_err` is 1 when `ref_mhz` is 0 or greater than 16, and 0 for 1 to 16.
- R7: With `vco_sel`=0, `vco_err` is 1 exactly when `ref_mhz` times the multiplier is below 128 or above 544.
- R8: With `vco_sel`=1, `vco_err` is 1 exactly when `ref_mhz` times the multiplier is below 150 or above 420.
- R9: The three error flags are registered. They reflect the stored code and the inputs as sampled at the previous rising edge, so an accepted write changes them one cycle after `rd_code` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for the multiplier code |
| wr_code | input | 9 | Code to write (multiplier minus one) |
| pll_on | input | 1 | PLL enable status |
| pll_rdy | input | 1 | PLL lock-ready status |
| ref_mhz | input | 6 | Reference frequency, integer MHz |
| vco_sel | input | 1 | VCO range select (0 wide window, 1 narrow window) |
| rd_code | output | 9 | Currently stored code |
| mult | output | 10 | Decoded multiplier |
| wr_reject | output | 1 | One-cycle pulse after a blocked write |
| code_err | output | 1 | Illegal code flag |
| ref_err | output | 1 | Reference out of range flag |
| vco_err | output | 1 | VCO frequency outside the selected window |

## Verification
A vector table sweeps codes, reference values and range selects so that each window edge is hit from both sides: 128 and 544 against 560 for the wide window, and 149, 150, 420 and 421 for the narrow one. The same product of 149 is run under both selects, which shows that the select picks the window. Illegal codes are tried at both ends (0, 6, 420, 511) together with legal neighbours 7 and 419, and references of 0 and 17 are tried against legal ones. This keeps the code check, the reference check and the VCO check apart. Directed tests block writes through each of the two status inputs on its own, and one test follows the flag latency cycle by cycle.

// File: rtl/pll_mult_pkg.sv
package pll_mult_pkg;
  typedef struct packed {
    logic code_bad;
    logic ref_bad;
    logic vco_bad;
  } cfg_err_t;
endpackage

// File: rtl/pll_mult_store.sv
module pll_mult_store #(
  parameter int CODE_W   = 9,
  parameter int RST_CODE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              pll_on,
  input  logic              pll_rdy,
  output logic [CODE_W-1:0] code_q,
  output logic              reject_q
);
  localparam logic [CODE_W-1:0] RST_VAL = CODE_W'(RST_CODE);

  logic pll_idle;
  assign pll_idle = !pll_on && !pll_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= RST_VAL;
      reject_q <= 1'b0;
    end else begin
      reject_q <= wr_en && !pll_idle;
      if (wr_en && pll_idle) code_q <= wr_code;
    end
  end
endmodule

// File: rtl/pll_mult_check.sv
module pll_mult_check
  import pll_mult_pkg::*;
#(
  parameter int CODE_W   = 9,
  parameter int REF_W    = 6,
  parameter int CODE_MIN = 7,
  parameter int CODE_MAX = 419,
  parameter int REF_MIN  = 1,
  parameter int REF_MAX  = 16,
  parameter int WIN0_LO  = 128,
  parameter int WIN0_HI  = 544,
  parameter int WIN1_LO  = 150,
  parameter int WIN1_HI  = 420
) (
  input  logic [CODE_W-1:0]   code,
  input  logic [REF_W-1:0]    ref_mhz,
  input  logic                vco_sel,
  output logic [CODE_W:0]     factor,
  output cfg_err_t            err
);
  localparam int FACT_W = CODE_W + 1;
  localparam int FREQ_W = REF_W + FACT_W;
  localparam logic [CODE_W-1:0] C_LO = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] C_HI = CODE_W'(CODE_MAX);
  localparam logic [REF_W-1:0]  R_LO = REF_W'(REF_MIN);
  localparam logic [REF_W-1:0]  R_HI = REF_W'(REF_MAX);
  localparam int WIN_LO [2] = '{WIN0_LO, WIN1_LO};
  localparam int WIN_HI [2] = '{WIN0_HI, WIN1_HI};

  logic [FREQ_W-1:0] vco_freq;
  logic [1:0]        in_win;

  assign factor   = FACT_W'(code) + FACT_W'(1);
  assign vco_freq = FREQ_W'(ref_mhz) * FREQ_W'(factor);

  for (genvar w = 0; w < 2; w++) begin : g_win
    localparam logic [FREQ_W-1:0] LO = FREQ_W'(WIN_LO[w]);
    localparam logic [FREQ_W-1:0] HI = FREQ_W'(WIN_HI[w]);
    assign in_win[w] = (vco_freq >= LO) && (vco_freq <= HI);
  end

  always_comb begin
    err.code_bad = (code < C_LO) || (code > C_HI);
    err.ref_bad  = (ref_mhz < R_LO) || (ref_mhz > R_HI);
    err.vco_bad  = !in_win[vco_sel];
  end
endmodule

// File: rtl/pll_mult_cfg.sv
module pll_mult_cfg
  import pll_mult_pkg::*;
#(
  parameter int CODE_W   = 9,
  parameter int REF_W    = 6,
  parameter int RST_CODE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              pll_on,
  input  logic              pll_rdy,
  input  logic [REF_W-1:0]  ref_mhz,
  input  logic              vco_sel,
  output logic [CODE_W-1:0] rd_code,
  output logic [CODE_W:0]   mult,
  output logic              wr_reject,
  output logic              code_err,
  output logic              ref_err,
  output logic              vco_err
);
  cfg_err_t err_d, err_q;
  logic [CODE_W-1:0] code_q;

  pll_mult_store #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .pll_on(pll_on), .pll_rdy(pll_rdy),
    .code_q(code_q), .reject_q(wr_reject)
  );

  pll_mult_check #(.CODE_W(CODE_W), .REF_W(REF_W)) u_check (
    .code(code_q), .ref_mhz(ref_mhz), .vco_sel(vco_sel),
    .factor(mult), .err(err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_d;
  end

  assign rd_code  = code_q;
  assign code_err = err_q.code_bad;
  assign ref_err  = err_q.ref_bad;
  assign vco_err  = err_q.vco_bad;
endmodule

// File: rtl/pll_mult_chk.sv
module pll_mult_chk #(
  parameter int CODE_W = 9,
  parameter int REF_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CODE_W-1:0] wr_code,
  input logic              pll_on,
  input logic              pll_rdy,
  input logic [REF_W-1:0]  ref_mhz,
  input logic [CODE_W-1:0] rd_code,
  input logic              wr_reject,
  input logic              code_err,
  input logic              ref_err
);
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pll_on && !pll_rdy) |=> (rd_code == $past(wr_code))); // R2
  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (pll_on || pll_rdy)) |=> $stable(rd_code)); // R3
  AST_REJECT_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (pll_on || pll_rdy)) |=> wr_reject); // R3
  AST_REJECT_CLR: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (pll_on || pll_rdy)) |=> !wr_reject); // R3
  AST_LOW_CODE: assert property (@(posedge clk) disable iff (rst)
    (rd_code < CODE_W'(7)) |=> code_err); // R5
  AST_REF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ref_mhz == '0) |=> ref_err); // R6
endmodule

bind pll_mult_cfg pll_mult_chk #(.CODE_W(CODE_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
  .pll_on(pll_on), .pll_rdy(pll_rdy), .ref_mhz(ref_mhz),
  .rd_code(rd_code), .wr_reject(wr_reject),
  .code_err(code_err), .ref_err(ref_err)
);

// File: tb/test_pll_mult_cfg.sv
module test_pll_mult_cfg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [8:0] wr_code = '0;
  logic       pll_on = 1'b0;
  logic       pll_rdy = 1'b0;
  logic [5:0] ref_mhz = 6'd1;
  logic       vco_sel = 1'b0;
  logic [8:0] rd_code;
  logic [9:0] mult;
  logic       wr_reject, code_err, ref_err, vco_err;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pll_mult_cfg i_pll_mult_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .pll_on(pll_on), .pll_rdy(pll_rdy), .ref_mhz(ref_mhz), .vco_sel(vco_sel),
    .rd_code(rd_code), .mult(mult), .wr_reject(wr_reject),
    .code_err(code_err), .ref_err(ref_err), .vco_err(vco_err)
  );

  typedef struct packed {
    logic [8:0] code;
    logic [5:0] rf;
    logic       sel;
    logic       ce;
    logic       re;
    logic       ve;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{9'd128, 6'd1,  1'b0, 1'b0, 1'b0, 1'b0},  // 129
    '{9'd6,   6'd16, 1'b0, 1'b1, 1'b0, 1'b1},  // 112
    '{9'd7,   6'd16, 1'b0, 1'b0, 1'b0, 1'b0},  // 128
    '{9'd33,  6'd16, 1'b0, 1'b0, 1'b0, 1'b0},  // 544
    '{9'd34,  6'd16, 1'b0, 1'b0, 1'b0, 1'b1},  // 560
    '{9'd419, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0},  // 420
    '{9'd420, 6'd1,  1'b1, 1'b1, 1'b0, 1'b1},  // 421
    '{9'd149, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0},  // 150
    '{9'd148, 6'd1,  1'b1, 1'b0, 1'b0, 1'b1},  // 149 narrow
    '{9'd148, 6'd1,  1'b0, 1'b0, 1'b0, 1'b0},  // 149 wide
    '{9'd128, 6'd0,  1'b0, 1'b0, 1'b1, 1'b1},  // 0
    '{9'd7,   6'd17, 1'b0, 1'b0, 1'b1, 1'b0},  // 136
    '{9'd0,   6'd16, 1'b0, 1'b1, 1'b0, 1'b1},  // 16
    '{9'd511, 6'd1,  1'b0, 1'b1, 1'b0, 1'b0}   // 512
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_code(input logic [8:0] c);
    @(negedge clk);
    wr_en = 1'b1;
    wr_code = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 code", int'(rd_code), 128);
    chk("R1 mult", int'(mult), 129);
    chk("R1 flags", int'({code_err, ref_err, vco_err, wr_reject}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post code", int'(rd_code), 128);
    chk("R1 post flags", int'({code_err, ref_err, vco_err, wr_reject}), 0);

    // vector table: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_code = VEC[i].code;
      ref_mhz = VEC[i].rf;
      vco_sel = VEC[i].sel;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      chk("R2 stored", int'(rd_code), int'(VEC[i].code));
      chk("R4 mult", int'(mult), int'(VEC[i].code) + 1);
      chk("R5 code_err", int'(code_err), int'(VEC[i].ce));
      chk("R6 ref_err", int'(ref_err), int'(VEC[i].re));
      chk(VEC[i].sel ? "R8 vco_err" : "R7 vco_err", int'(vco_err), int'(VEC[i].ve));
    end

    // R3 blocked by enable
    ref_mhz = 6'd1; vco_sel = 1'b0;
    write_code(9'd200);
    pll_on = 1'b1;
    write_code(9'd50);
    chk("R3 hold on", int'(rd_code), 200);
    chk("R3 reject pulse", int'(wr_reject), 1);
    @(negedge clk);
    chk("R3 reject clears", int'(wr_reject), 0);
    pll_on = 1'b0;
    // R3 blocked by ready
    pll_rdy = 1'b1;
    write_code(9'd3);
    chk("R3 hold rdy", int'(rd_code), 200);
    chk("R3 reject rdy", int'(wr_reject), 1);
    @(negedge clk);
    chk("R5 unchanged after block", int'(code_err), 0);
    pll_rdy = 1'b0;
    // R3 accepted write gives no pulse
    write_code(9'd3);
    chk("R3 no reject", int'(wr_reject), 0);
    // R9 latency: code already 3, flag still old this cycle
    chk("R9 code now", int'(rd_code), 3);
    chk("R9 flag lags", int'(code_err), 0);
    @(negedge clk);
    chk("R9 flag follows", int'(code_err), 1);
    // R9 reference change lags one edge
    @(negedge clk);
    ref_mhz = 6'd40;
    chk("R9 ref before edge", int'(ref_err), 0);
    @(negedge clk);
    chk("R9 ref after edge", int'(ref_err), 1);

    // R1 reset restores default
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again code", int'(rd_code), 128);
    chk("R1 reset again flags", int'({code_err, ref_err, vco_err}), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule